// File: doc/BRIEF.md
# Configuration Lock Manager

This block keeps the write-once lock bits that freeze a chip's configuration registers: a multiplexing lock, a global GPIO lock with eight per-pin GPIO locks, a fast-disable lock, a clock lock, four external-bus locks (I/O map, memory map, zone, host access), an eight-bit RAM-protection lock field and two power-timer locks (timer-reset and sleep-encoding). Software sets each lock by writing a 1 to its bit. After that, writing a 0 cannot release it.

A control register holds a sticky mode bit. The mode bit decides which reset domains may release the locks. With the mode bit at 0, any of the three resets releases them: standby power-up, main power-up or hardware. With the mode bit at 1, only the standby power-up reset releases them. The same register carries seven self-clearing unlock commands. Each command releases one lock group whatever the mode bit says. Every lock state drives an output pin toward the protected registers and can also be read back on the register bus.

Top module: `lock_manager`

## Requirements
- R1: After a standby power-up reset, every lock output is 0, the mode bit is 0, and every register address reads 0.
- R2: Each lock is set by a write of 1 to its bit and shows on its output one cycle after the write. A write of 0 never clears a set lock. The address map is as follows. Address 1 holds the core locks: bit 0 multiplexing, bit 1 GPIO global, bit 2 fast-disable, bit 3 clock. Address 2 holds the per-pin GPIO locks in bits 7:0. Address 3 holds the external-bus locks: bit 0 I/O map, bit 1 memory map, bit 2 zone, bit 3 host access. Address 4 holds the RAM-protection locks in bits 7:0. Address 5 holds the power-timer locks: bit 0 timer reset, bit 1 sleep encoding.
- R3: Bit 7 of the control register (address 0) is the mode bit. A write of 1 sets it. A write of 0 does not clear it. Main power-up and hardware resets leave it unchanged.
- R4: While the mode bit is 0, a main power-up reset or a hardware reset clears every lock.
- R5: While the mode bit is 1, main power-up and hardware resets leave every lock unchanged.
- R6: A standby power-up reset clears every lock and the mode bit in any state. It also overrides any write presented in the same cycle.
- R7: Each unlock command in the control register clears only its own group. Bit 6 clears the multiplexing lock. Bit 5 clears the GPIO global lock and all per-pin locks. Bit 4 clears fast-disable. Bit 3 clears clock. Bit 2 clears all four external-bus locks. Bit 1 clears all RAM-protection locks. Bit 0 clears both power-timer locks. Several command bits written together clear the union of their groups.
- R8: Unlock commands take effect with the mode bit at either value. A command write never changes the mode bit.
- R9: Address 0 reads as the mode bit in bit 7 with bits 6:0 at 0. Lock addresses read their current lock state, with unused upper bits at 0. Addresses 6 to 15 read 0, and writes to them have no effect.
- R10: Bus writes are ignored in any cycle in which any reset input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstStandby | input | 1 | Standby power-up reset, active high, synchronous |
| rstMain | input | 1 | Main power-up reset, active high, synchronous |
| rstHw | input | 1 | Hardware reset, active high, synchronous |
| addr | input | 4 | Register address |
| wrEn | input | 1 | Write enable |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the register at addr (combinational) |
| lockMux | output | 1 | Multiplexing lock |
| lockGpio | output | 1 | GPIO global lock |
| lockPin | output | 8 | Per-pin GPIO locks |
| lockFast | output | 1 | Fast-disable lock |
| lockClk | output | 1 | Clock lock |
| lockXbus | output | 4 | External-bus locks (I/O map, memory map, zone, host access) |
| lockRam | output | 8 | RAM-protection locks |
| lockTimer | output | 2 | Power-timer locks (timer reset, sleep encoding) |

## Verification
The hardest case to reach is a reset and a bus write in the same cycle. A single-port bus cannot otherwise present a write while the reset logic is deciding what to clear. The bench raises a reset input and the write enable on the same falling edge. It does this with the mode bit at both values and with all three resets. It then checks that a reset which does not qualify leaves the locks as they were and that the write still does not land. To cover the group routing, the bench first fills every lock and then issues each unlock command alone, under both mode values. It also sweeps all 256 patterns of the per-pin and RAM-protection fields.

// File: rtl/lock_pkg.sv
package lock_pkg;

  localparam int BUS_W    = 8;
  localparam int ADDR_W   = 4;
  localparam int UNLOCK_N = 7;
  localparam int REG_N    = 6;
  localparam int MODE_BIT = 7;

  // register indices
  localparam int REG_CTRL  = 0;
  localparam int REG_CORE  = 1;
  localparam int REG_PIN   = 2;
  localparam int REG_XBUS  = 3;
  localparam int REG_RAM   = 4;
  localparam int REG_TIMER = 5;

  // unlock command positions in the control register
  localparam int UL_TIMER = 0;
  localparam int UL_RAM   = 1;
  localparam int UL_XBUS  = 2;
  localparam int UL_CLK   = 3;
  localparam int UL_FAST  = 4;
  localparam int UL_GPIO  = 5;
  localparam int UL_MUX   = 6;

  // core lock register bit order
  localparam int CORE_MUX  = 0;
  localparam int CORE_GPIO = 1;
  localparam int CORE_FAST = 2;
  localparam int CORE_CLK  = 3;
  localparam int CORE_N    = 4;

  typedef struct packed {
    logic                clrAll;   // qualifying reset
    logic [UNLOCK_N-1:0] unlock;   // per-group unlock strobes
    logic [REG_N-1:0]    wrSel;    // one-hot accepted write select
    logic [BUS_W-1:0]    data;     // write data
  } lockStrobe_t;

  function automatic int coreUnlockBit(int idx);
    case (idx)
      CORE_MUX:  return UL_MUX;
      CORE_GPIO: return UL_GPIO;
      CORE_FAST: return UL_FAST;
      default:   return UL_CLK;
    endcase
  endfunction

endpackage

// File: rtl/lock_group.sv
module lock_group #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [WIDTH-1:0] setBits,
  output logic [WIDTH-1:0] q
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    // clear outranks set, set outranks hold
    always_ff @(posedge clk) begin
      if (clr)             q[i] <= 1'b0;
      else if (setBits[i]) q[i] <= 1'b1;
    end
  end

  // R7: a clear strobe empties the whole group on the next cycle
  p_group_clear_r7: assert property (@(posedge clk) clr |=> (q == '0));

  // R2: a set lock survives every cycle without a clear
  p_write_once_r2: assert property (@(posedge clk) disable iff (clr)
    (q != '0) |=> ((q & $past(q)) == $past(q)));

endmodule

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import lock_pkg::*;
#(
  parameter int PIN_COUNT   = 8,
  parameter int RAM_BITS    = 8,
  parameter int XBUS_LOCKS  = 4,
  parameter int TIMER_LOCKS = 2
) (
  input  logic                   clk,
  input  logic                   rstStandby,
  input  logic                   rstMain,
  input  logic                   rstHw,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wrEn,
  input  logic [BUS_W-1:0]       wrData,
  input  logic [CORE_N-1:0]      coreLocks,
  input  logic [PIN_COUNT-1:0]   pinLocks,
  input  logic [XBUS_LOCKS-1:0]  xbusLocks,
  input  logic [RAM_BITS-1:0]    ramLocks,
  input  logic [TIMER_LOCKS-1:0] timerLocks,
  output lockStrobe_t            strobe,
  output logic                   modeBit,
  output logic [BUS_W-1:0]       rdData
);

  logic anyReset;
  logic wrOk;
  logic ctrlWrite;

  assign anyReset  = rstStandby | rstMain | rstHw;
  assign wrOk      = wrEn & ~anyReset;
  assign ctrlWrite = wrOk && (addr == ADDR_W'(REG_CTRL));

  // sticky mode bit: only the standby reset returns it to 0
  always_ff @(posedge clk) begin
    if (rstStandby)                        modeBit <= 1'b0;
    else if (ctrlWrite && wrData[MODE_BIT]) modeBit <= 1'b1;
  end

  assign strobe.clrAll = rstStandby | (~modeBit & (rstMain | rstHw));
  assign strobe.unlock = ctrlWrite ? wrData[UNLOCK_N-1:0] : '0;
  assign strobe.data   = wrData;

  for (genvar i = 0; i < REG_N; i++) begin : g_sel
    assign strobe.wrSel[i] = wrOk && (addr == ADDR_W'(i));
  end

  always_comb begin
    rdData = '0;
    case (addr)
      ADDR_W'(REG_CTRL):  rdData[MODE_BIT] = modeBit;
      ADDR_W'(REG_CORE):  rdData = BUS_W'(coreLocks);
      ADDR_W'(REG_PIN):   rdData = BUS_W'(pinLocks);
      ADDR_W'(REG_XBUS):  rdData = BUS_W'(xbusLocks);
      ADDR_W'(REG_RAM):   rdData = BUS_W'(ramLocks);
      ADDR_W'(REG_TIMER): rdData = BUS_W'(timerLocks);
      default:            rdData = '0;
    endcase
  end

  // R3: once set, the mode bit stays set until a standby reset
  p_mode_sticky_r3: assert property (@(posedge clk) disable iff (rstStandby)
    modeBit |=> modeBit);

  // R6: standby reset always returns the mode bit to 0
  p_standby_mode_r6: assert property (@(posedge clk) rstStandby |=> !modeBit);

  // R9: unlock commands read back as zero
  p_cmd_reads_zero_r9: assert property (@(posedge clk) disable iff (rstStandby)
    (addr == ADDR_W'(REG_CTRL)) |-> (rdData[UNLOCK_N-1:0] == '0));

endmodule

// File: rtl/lock_datapath.sv
module lock_datapath
  import lock_pkg::*;
#(
  parameter int PIN_COUNT   = 8,
  parameter int RAM_BITS    = 8,
  parameter int XBUS_LOCKS  = 4,
  parameter int TIMER_LOCKS = 2
) (
  input  logic                   clk,
  input  logic                   rstStandby,
  input  logic                   rstMain,
  input  logic                   rstHw,
  input  logic                   modeBit,
  input  lockStrobe_t            strobe,
  output logic [CORE_N-1:0]      coreLocks,
  output logic [PIN_COUNT-1:0]   pinLocks,
  output logic [XBUS_LOCKS-1:0]  xbusLocks,
  output logic [RAM_BITS-1:0]    ramLocks,
  output logic [TIMER_LOCKS-1:0] timerLocks
);

  localparam int STATE_W = CORE_N + PIN_COUNT + XBUS_LOCKS + RAM_BITS + TIMER_LOCKS;

  logic [STATE_W-1:0] allLocks;
  logic               sideReset;

  assign allLocks  = {coreLocks, pinLocks, xbusLocks, ramLocks, timerLocks};
  assign sideReset = rstMain | rstHw;

  // core locks: one group per bit, each with its own unlock command
  for (genvar i = 0; i < CORE_N; i++) begin : g_core
    lock_group #(.WIDTH(1)) u_core (
      .clk     (clk),
      .clr     (strobe.clrAll | strobe.unlock[coreUnlockBit(i)]),
      .setBits (strobe.wrSel[REG_CORE] & strobe.data[i]),
      .q       (coreLocks[i])
    );
  end

  // per-pin GPIO locks share the GPIO unlock command with the global lock
  lock_group #(.WIDTH(PIN_COUNT)) u_pin (
    .clk     (clk),
    .clr     (strobe.clrAll | strobe.unlock[UL_GPIO]),
    .setBits ({PIN_COUNT{strobe.wrSel[REG_PIN]}} & strobe.data[PIN_COUNT-1:0]),
    .q       (pinLocks)
  );

  lock_group #(.WIDTH(XBUS_LOCKS)) u_xbus (
    .clk     (clk),
    .clr     (strobe.clrAll | strobe.unlock[UL_XBUS]),
    .setBits ({XBUS_LOCKS{strobe.wrSel[REG_XBUS]}} & strobe.data[XBUS_LOCKS-1:0]),
    .q       (xbusLocks)
  );

  lock_group #(.WIDTH(RAM_BITS)) u_ram (
    .clk     (clk),
    .clr     (strobe.clrAll | strobe.unlock[UL_RAM]),
    .setBits ({RAM_BITS{strobe.wrSel[REG_RAM]}} & strobe.data[RAM_BITS-1:0]),
    .q       (ramLocks)
  );

  lock_group #(.WIDTH(TIMER_LOCKS)) u_timer (
    .clk     (clk),
    .clr     (strobe.clrAll | strobe.unlock[UL_TIMER]),
    .setBits ({TIMER_LOCKS{strobe.wrSel[REG_TIMER]}} & strobe.data[TIMER_LOCKS-1:0]),
    .q       (timerLocks)
  );

  // R4: with the mode bit clear, a main or hardware reset empties every lock
  p_plain_reset_r4: assert property (@(posedge clk)
    (!modeBit && sideReset) |=> (allLocks == '0));

  // R5: with the mode bit set, a main or hardware reset freezes every lock
  p_sticky_hold_r5: assert property (@(posedge clk) disable iff (rstStandby)
    (modeBit && sideReset) |=> (allLocks == $past(allLocks)));

  // R6: standby reset empties every lock
  p_standby_clear_r6: assert property (@(posedge clk) rstStandby |=> (allLocks == '0));

endmodule

// File: rtl/lock_manager.sv
module lock_manager
  import lock_pkg::*;
#(
  parameter int PIN_COUNT   = 8,
  parameter int RAM_BITS    = 8,
  parameter int XBUS_LOCKS  = 4,
  parameter int TIMER_LOCKS = 2
) (
  input  logic                   clk,
  input  logic                   rstStandby,
  input  logic                   rstMain,
  input  logic                   rstHw,
  input  logic [3:0]             addr,
  input  logic                   wrEn,
  input  logic [7:0]             wrData,
  output logic [7:0]             rdData,
  output logic                   lockMux,
  output logic                   lockGpio,
  output logic [PIN_COUNT-1:0]   lockPin,
  output logic                   lockFast,
  output logic                   lockClk,
  output logic [XBUS_LOCKS-1:0]  lockXbus,
  output logic [RAM_BITS-1:0]    lockRam,
  output logic [TIMER_LOCKS-1:0] lockTimer
);

  lockStrobe_t           strobe;
  logic                  modeBit;
  logic [CORE_N-1:0]     coreLocks;

  lock_ctrl #(
    .PIN_COUNT   (PIN_COUNT),
    .RAM_BITS    (RAM_BITS),
    .XBUS_LOCKS  (XBUS_LOCKS),
    .TIMER_LOCKS (TIMER_LOCKS)
  ) u_ctrl (
    .clk        (clk),
    .rstStandby (rstStandby),
    .rstMain    (rstMain),
    .rstHw      (rstHw),
    .addr       (addr),
    .wrEn       (wrEn),
    .wrData     (wrData),
    .coreLocks  (coreLocks),
    .pinLocks   (lockPin),
    .xbusLocks  (lockXbus),
    .ramLocks   (lockRam),
    .timerLocks (lockTimer),
    .strobe     (strobe),
    .modeBit    (modeBit),
    .rdData     (rdData)
  );

  lock_datapath #(
    .PIN_COUNT   (PIN_COUNT),
    .RAM_BITS    (RAM_BITS),
    .XBUS_LOCKS  (XBUS_LOCKS),
    .TIMER_LOCKS (TIMER_LOCKS)
  ) u_data (
    .clk        (clk),
    .rstStandby (rstStandby),
    .rstMain    (rstMain),
    .rstHw      (rstHw),
    .modeBit    (modeBit),
    .strobe     (strobe),
    .coreLocks  (coreLocks),
    .pinLocks   (lockPin),
    .xbusLocks  (lockXbus),
    .ramLocks   (lockRam),
    .timerLocks (lockTimer)
  );

  assign lockMux  = coreLocks[CORE_MUX];
  assign lockGpio = coreLocks[CORE_GPIO];
  assign lockFast = coreLocks[CORE_FAST];
  assign lockClk  = coreLocks[CORE_CLK];

endmodule

// File: tb/tb_lock_manager.sv
`timescale 1ns/100ps
module tb_lock_manager;

  logic       clk = 1'b0;
  logic       rstStandby = 1'b0, rstMain = 1'b0, rstHw = 1'b0;
  logic [3:0] addr = '0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       lockMux, lockGpio, lockFast, lockClk;
  logic [7:0] lockPin, lockRam;
  logic [3:0] lockXbus;
  logic [1:0] lockTimer;

  int errors = 0;
  int checks = 0;

  // bench model
  logic       mMode;
  logic [3:0] mCore, mXbus;
  logic [7:0] mPin, mRam;
  logic [1:0] mTimer;

  always #4 clk = ~clk;   // 125 MHz

  lock_manager dut (
    .clk(clk), .rstStandby(rstStandby), .rstMain(rstMain), .rstHw(rstHw),
    .addr(addr), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .lockMux(lockMux), .lockGpio(lockGpio), .lockPin(lockPin),
    .lockFast(lockFast), .lockClk(lockClk), .lockXbus(lockXbus),
    .lockRam(lockRam), .lockTimer(lockTimer)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expRead(int a);
    case (a)
      0: return {mMode, 7'b0};
      1: return {4'b0, mCore};
      2: return mPin;
      3: return {4'b0, mXbus};
      4: return mRam;
      5: return {6'b0, mTimer};
      default: return 8'h00;
    endcase
  endfunction

  task automatic checkAll(string tag);
    check({tag, " core out"},  {4'b0, lockClk, lockFast, lockGpio, lockMux}, {4'b0, mCore});
    check({tag, " pin out"},   lockPin, mPin);
    check({tag, " xbus out"},  {4'b0, lockXbus}, {4'b0, mXbus});
    check({tag, " ram out"},   lockRam, mRam);
    check({tag, " timer out"}, {6'b0, lockTimer}, {6'b0, mTimer});
    for (int a = 0; a < 16; a++) begin
      addr = 4'(a);
      #0.2;
      check($sformatf("%s read %0d", tag, a), rdData, expRead(a));
    end
  endtask

  function automatic void modelWrite(int a, logic [7:0] d);
    case (a)
      0: begin
        if (d[7]) mMode = 1'b1;
        if (d[6]) mCore[0] = 1'b0;
        if (d[5]) begin mCore[1] = 1'b0; mPin = '0; end
        if (d[4]) mCore[2] = 1'b0;
        if (d[3]) mCore[3] = 1'b0;
        if (d[2]) mXbus = '0;
        if (d[1]) mRam = '0;
        if (d[0]) mTimer = '0;
      end
      1: mCore  = mCore  | d[3:0];
      2: mPin   = mPin   | d;
      3: mXbus  = mXbus  | d[3:0];
      4: mRam   = mRam   | d;
      5: mTimer = mTimer | d[1:0];
      default: ;
    endcase
  endfunction

  task automatic busWrite(int a, logic [7:0] d);
    @(negedge clk);
    addr = 4'(a); wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    modelWrite(a, d);
  endtask

  // kind: 0 standby, 1 main, 2 hardware; optional concurrent write (ignored)
  task automatic pulseReset(int kind, bit withWrite, int a, logic [7:0] d);
    @(negedge clk);
    rstStandby = (kind == 0);
    rstMain    = (kind == 1);
    rstHw      = (kind == 2);
    if (withWrite) begin addr = 4'(a); wrData = d; wrEn = 1'b1; end
    @(negedge clk);
    rstStandby = 1'b0; rstMain = 1'b0; rstHw = 1'b0; wrEn = 1'b0;
    if (kind == 0) begin
      mMode = 1'b0; mCore = '0; mPin = '0; mXbus = '0; mRam = '0; mTimer = '0;
    end else if (!mMode) begin
      mCore = '0; mPin = '0; mXbus = '0; mRam = '0; mTimer = '0;
    end
  endtask

  task automatic fillAll();
    for (int a = 1; a <= 5; a++) busWrite(a, 8'hFF);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    mMode = 0; mCore = 0; mPin = 0; mXbus = 0; mRam = 0; mTimer = 0;

    // R1: reset state
    pulseReset(0, 0, 0, 0);
    checkAll("R1");

    // R2: each lock bit sets on its own, zero writes do not clear
    for (int a = 1; a <= 5; a++) begin
      for (int b = 0; b < 8; b++) begin
        busWrite(a, 8'(1 << b));
        checkAll("R2 set");
      end
      busWrite(a, 8'h00);
      checkAll("R2 zero write");
    end

    // R9: unmapped addresses ignore writes
    pulseReset(0, 0, 0, 0);
    for (int a = 6; a < 16; a++) busWrite(a, 8'hFF);
    checkAll("R9 unmapped");

    // R3: mode bit behaviour
    fillAll();
    busWrite(0, 8'h00);
    checkAll("R3 zero write");
    busWrite(0, 8'h80);
    checkAll("R3 set");
    busWrite(0, 8'h00);
    checkAll("R3 hold");
    pulseReset(1, 0, 0, 0);
    checkAll("R3 main reset");
    pulseReset(2, 0, 0, 0);
    checkAll("R3 hw reset");

    // R4 / R5: side resets under each mode
    for (int m = 0; m < 2; m++) begin
      for (int k = 1; k <= 2; k++) begin
        pulseReset(0, 0, 0, 0);
        if (m == 1) busWrite(0, 8'h80);
        fillAll();
        pulseReset(k, 0, 0, 0);
        checkAll(m == 0 ? "R4" : "R5");
      end
    end

    // R7 / R8: each unlock command alone, both modes
    for (int m = 0; m < 2; m++) begin
      for (int u = 0; u < 7; u++) begin
        pulseReset(0, 0, 0, 0);
        if (m == 1) busWrite(0, 8'h80);
        fillAll();
        busWrite(0, 8'(1 << u));
        checkAll(m == 0 ? "R7" : "R8");
      end
      fillAll();
      busWrite(0, 8'h7F);
      checkAll("R7 all commands");
    end

    // R6: standby reset beats a concurrent write in mode 1
    pulseReset(0, 0, 0, 0);
    busWrite(0, 8'h80);
    fillAll();
    pulseReset(0, 1, 0, 8'h80);
    checkAll("R6 ctrl write");
    pulseReset(0, 1, 1, 8'h0F);
    checkAll("R6 lock write");

    // R10: writes during a side reset are dropped
    busWrite(0, 8'h80);
    pulseReset(1, 1, 1, 8'h0F);
    checkAll("R10 mode1 main");
    pulseReset(2, 1, 4, 8'hAA);
    checkAll("R10 mode1 hw");
    pulseReset(0, 0, 0, 0);
    pulseReset(2, 1, 2, 8'hFF);
    checkAll("R10 mode0 hw");
    pulseReset(1, 1, 0, 8'h80);
    checkAll("R10 mode0 main ctrl");

    // R2 / R7: full pattern sweeps on the wide groups
    pulseReset(0, 0, 0, 0);
    for (int v = 0; v < 256; v++) begin
      busWrite(2, 8'(v));
      busWrite(4, 8'(255 - v));
      checkAll("R2 sweep");
      busWrite(0, 8'h22);
      check("R7 sweep pin", lockPin, 8'h00);
      check("R7 sweep ram", lockRam, 8'h00);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule